// File: doc/BRIEF.md
# Watchdog Timer with Shared Rate Scaler

This block is a watchdog whose 8-bit base counter advances on its own free-running tick enable. It therefore keeps running while the processor clock that drives the rest of the device is halted in sleep. A single 8-bit rate scaler is shared with a general-purpose timer, and an owner bit decides which of the two uses it. With the owner bit at 0 the scaler divides the general timer's source tick, and every base-counter overflow is a watchdog time-out. With the owner bit at 1 the scaler counts base-counter overflows and stretches the time-out period. In that mode the general timer receives its source tick undivided.

Software keeps the watchdog quiet with a clear strobe. A sleep-entry strobe has the same effect. Either strobe restarts the base counter and, when the watchdog owns the scaler, the scaler count as well. Neither strobe touches the owner bit or the rate select. A time-out gives a one-cycle device-reset pulse while the device is awake, or a one-cycle wake-up pulse while the sleep flag is set. Every time-out also drops an active-low status flag. A configuration enable of 0 turns the watchdog off entirely.

Top module: `wdog_shared_scaler`

## Requirements
- R1: After reset, dev_reset_o, wake_o and tmr_tick_o are 0 and to_n_o is 1.
- R2: With scaler_to_wd_i=0 and wd_en_i=1, a time-out occurs on the 256th wd_tick_i after a clear. Its pulse is visible in the cycle after the clock edge that sampled that tick.
- R3: With scaler_to_wd_i=1, the time-out period is 256 x 2^(rate_i+1) watchdog ticks after a clear. rate_i=0 selects divide-by-2 and rate_i=7 selects divide-by-256.
- R4: With scaler_to_wd_i=0, tmr_tick_o pulses once every 2^(rate_i+1) cycles that have tmr_src_tick_i high. Each pulse appears one cycle after the tick that completes the count.
- R5: With scaler_to_wd_i=1, tmr_tick_o equals tmr_src_tick_i from the previous cycle.
- R6: clr_wd_i or sleep_enter_i restarts the base counter. It clears the scaler count only when scaler_to_wd_i=1, so the timer tick phase is kept when scaler_to_wd_i=0. The postscaled period that follows a clear is the full R3 period.
- R7: A time-out while sleep_i=0 gives dev_reset_o=1 for exactly one cycle and wake_o=0.
- R8: A time-out while sleep_i=1 gives wake_o=1 for exactly one cycle and dev_reset_o=0.
- R9: Every time-out sets to_n_o to 0. It stays 0 until a clr_wd_i or sleep_enter_i, which sets it to 1 on the next edge.
- R10: With wd_en_i=0 there are no time-outs and the base counter does not advance.
- R11: A clear strobe in the same cycle as the overflowing watchdog tick suppresses that time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Power-on reset, active low |
| wd_tick_i | input | 1 | Watchdog free-running tick enable |
| tmr_src_tick_i | input | 1 | General timer source tick enable |
| clr_wd_i | input | 1 | Clear-watchdog strobe |
| sleep_enter_i | input | 1 | Sleep-entry strobe |
| sleep_i | input | 1 | Device is asleep |
| wd_en_i | input | 1 | Configuration enable of the watchdog |
| scaler_to_wd_i | input | 1 | Scaler owner: 1 = watchdog postscaler, 0 = timer prescaler |
| rate_i | input | 3 | Scaler tap select, divide by 2^(rate_i+1) |
| dev_reset_o | output | 1 | Device-reset pulse |
| wake_o | output | 1 | Wake-up pulse |
| to_n_o | output | 1 | Time-out status, 0 after a time-out |
| tmr_tick_o | output | 1 | Scaled tick for the general timer |

## Verification
Directed runs that tick on every cycle measure the exact time-out distance for the base overflow alone and for two postscaler rates. This separates an off-by-one in the overflow from a wrong tap. A dense timer source tick spaces tmr_tick_o pulses by the selected rate, and a clear placed between pulses shows whether the prescaler phase is wrongly reset. Sleep-flag and disable runs tell a reset pulse from a wake pulse from none at all, and a clear on the overflowing tick checks the priority of R11. A long random phase with sparse clears, owner flips and rate changes is then compared cycle by cycle against a reference model in the bench.

// File: rtl/wdsc_pkg.sv
package wdsc_pkg;
   typedef enum logic {
      SCL_OWNER_TIMER = 1'b0,
      SCL_OWNER_WDOG  = 1'b1
   } scl_owner_e;

   // Number of taps a select of the given width can address.
   function automatic int unsigned tap_count(input int unsigned sel_w);
      return 32'd1 << sel_w;
   endfunction
endpackage

// File: rtl/wdsc_base_cnt.sv
module wdsc_base_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic en_i,
   input  logic clr_i,
   output logic ovf_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             adv;

   if (CNT_W < 2) begin : g_bad_width
      $error("wdsc_base_cnt: CNT_W must be at least 2");
   end

   assign adv   = tick_i & en_i;
   assign ovf_o = adv & (&cnt_q) & ~clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/wdsc_scaler.sv
module wdsc_scaler #(
   parameter int unsigned SCL_W = 8,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tap_o
);
   localparam int unsigned   N_TAP = wdsc_pkg::tap_count(SEL_W);
   localparam logic [SCL_W-1:0] ONE = SCL_W'(1);

   logic [SCL_W-1:0] cnt_q;
   logic [N_TAP-1:0] hit;

   if (N_TAP > SCL_W) begin : g_bad_taps
      $error("wdsc_scaler: tap select addresses more stages than SCL_W");
   end

   // Tap g completes a divide-by-2^(g+1) period when its low bits are all ones.
   for (genvar g = 0; g < N_TAP; g++) begin : g_tap
      assign hit[g] = &cnt_q[g:0];
   end

   assign tap_o = evt_i & hit[sel_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (evt_i) begin
         cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/wdsc_evt.sv
module wdsc_evt (
   input  logic clk,
   input  logic rst_n,
   input  logic timeout_i,
   input  logic sleep_i,
   input  logic clr_i,
   input  logic tmr_evt_i,
   output logic dev_reset_o,
   output logic wake_o,
   output logic to_n_o,
   output logic tmr_tick_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_reset_o <= 1'b0;
         wake_o      <= 1'b0;
         to_n_o      <= 1'b1;
         tmr_tick_o  <= 1'b0;
      end else begin
         dev_reset_o <= timeout_i & ~sleep_i;
         wake_o      <= timeout_i & sleep_i;
         tmr_tick_o  <= tmr_evt_i;
         if (clr_i) begin
            to_n_o <= 1'b1;
         end else if (timeout_i) begin
            to_n_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wdog_shared_scaler.sv
module wdog_shared_scaler #(
   parameter int unsigned BASE_W = 8,
   parameter int unsigned SCL_W  = 8,
   parameter int unsigned SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wd_tick_i,
   input  logic             tmr_src_tick_i,
   input  logic             clr_wd_i,
   input  logic             sleep_enter_i,
   input  logic             sleep_i,
   input  logic             wd_en_i,
   input  logic             scaler_to_wd_i,
   input  logic [SEL_W-1:0] rate_i,
   output logic             dev_reset_o,
   output logic             wake_o,
   output logic             to_n_o,
   output logic             tmr_tick_o
);
   import wdsc_pkg::*;

   scl_owner_e owner;
   logic       clr_any;
   logic       base_ovf;
   logic       scl_evt;
   logic       scl_clr;
   logic       scl_tap;
   logic       timeout;
   logic       tmr_evt;

   assign owner   = scl_owner_e'(scaler_to_wd_i);
   assign clr_any = clr_wd_i | sleep_enter_i;

   wdsc_base_cnt #(.CNT_W(BASE_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (wd_tick_i),
      .en_i   (wd_en_i),
      .clr_i  (clr_any),
      .ovf_o  (base_ovf)
   );

   always_comb begin
      if (owner == SCL_OWNER_WDOG) begin
         scl_evt = base_ovf;
         scl_clr = clr_any;
         timeout = wd_en_i & scl_tap;
         tmr_evt = tmr_src_tick_i;
      end else begin
         scl_evt = tmr_src_tick_i;
         scl_clr = 1'b0;
         timeout = wd_en_i & base_ovf;
         tmr_evt = scl_tap;
      end
   end

   wdsc_scaler #(.SCL_W(SCL_W), .SEL_W(SEL_W)) u_scl (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (scl_evt),
      .clr_i  (scl_clr),
      .sel_i  (rate_i),
      .tap_o  (scl_tap)
   );

   wdsc_evt u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .timeout_i   (timeout),
      .sleep_i     (sleep_i),
      .clr_i       (clr_any),
      .tmr_evt_i   (tmr_evt),
      .dev_reset_o (dev_reset_o),
      .wake_o      (wake_o),
      .to_n_o      (to_n_o),
      .tmr_tick_o  (tmr_tick_o)
   );
endmodule

// File: rtl/wdsc_chk.sv
module wdsc_chk #(
   parameter int unsigned BASE_W = 8,
   parameter int unsigned SCL_W  = 8,
   parameter int unsigned SEL_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wd_tick_i,
   input logic             tmr_src_tick_i,
   input logic             clr_wd_i,
   input logic             sleep_enter_i,
   input logic             sleep_i,
   input logic             wd_en_i,
   input logic             scaler_to_wd_i,
   input logic [SEL_W-1:0] rate_i,
   input logic             dev_reset_o,
   input logic             wake_o,
   input logic             to_n_o,
   input logic             tmr_tick_o
);
   assert_excl_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_reset_o && wake_o));

   assert_reset_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_reset_o |-> !$past(sleep_i));

   assert_wake_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> $past(sleep_i));

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_reset_o |=> !dev_reset_o);

   assert_status_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_reset_o || wake_o) |-> !to_n_o);

   assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wd_i || sleep_enter_i) |=> (to_n_o && !dev_reset_o && !wake_o));

   assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en_i |=> (!dev_reset_o && !wake_o));

   assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
      scaler_to_wd_i |=> (tmr_tick_o == $past(tmr_src_tick_i)));
endmodule

bind wdog_shared_scaler wdsc_chk #(.BASE_W(BASE_W), .SCL_W(SCL_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/wdog_shared_scaler_tb_top.sv
module wdog_shared_scaler_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wd_tick = 1'b0, src_tick = 1'b0, clr_wd = 1'b0, slp_enter = 1'b0;
   logic       sleep = 1'b0, en = 1'b1, asg = 1'b0;
   logic [2:0] rate = 3'd0;
   logic       dev_reset, wake, to_n, tmr_tick;

   int errors = 0;
   int checks = 0;
   int stepno = 0;
   bit done = 1'b0;

   // Reference model state
   int m_base = 0;
   int m_scl  = 0;
   logic m_to_n = 1'b1;

   always #2 clk = ~clk;

   wdog_shared_scaler dut_i (
      .clk(clk), .rst_n(rst_n), .wd_tick_i(wd_tick), .tmr_src_tick_i(src_tick),
      .clr_wd_i(clr_wd), .sleep_enter_i(slp_enter), .sleep_i(sleep), .wd_en_i(en),
      .scaler_to_wd_i(asg), .rate_i(rate), .dev_reset_o(dev_reset), .wake_o(wake),
      .to_n_o(to_n), .tmr_tick_o(tmr_tick)
   );

   function automatic bit tap_hit(input int scl, input logic [2:0] r);
      int mask;
      mask = (1 << (int'(r) + 1)) - 1;
      return (scl & mask) == mask;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (step %0d)", req, act, exp, stepno);
      end
   endtask

   // One clock step: model the edge from the inputs held now, then compare.
   task automatic step();
      bit clr, ovf, scl_in, tap, to;
      logic [3:0] e;
      string tag;
      @(posedge clk);
      clr    = clr_wd | slp_enter;
      ovf    = en && wd_tick && (m_base == 255) && !clr;
      scl_in = asg ? ovf : src_tick;
      tap    = scl_in && tap_hit(m_scl, rate);
      to     = en && (asg ? tap : ovf);
      e      = {to && !sleep, to && sleep, 1'b0, asg ? src_tick : tap};
      if (clr) m_to_n = 1'b1;
      else if (to) m_to_n = 1'b0;
      e[1] = m_to_n;
      if (clr) m_base = 0;
      else if (en && wd_tick) m_base = (m_base + 1) % 256;
      if (clr && asg) m_scl = 0;
      else if (scl_in) m_scl = (m_scl + 1) % 256;
      tag = e[3] ? "R7" : e[2] ? "R8" : asg ? "R3/R5" : "R2/R4";
      #1;
      stepno++;
      check({"model ", tag}, int'({dev_reset, wake, to_n, tmr_tick}), int'(e));
      clr_wd = 1'b0;
      slp_enter = 1'b0;
   endtask

   task automatic do_clear();
      clr_wd = 1'b1;
      wd_tick = 1'b0;
      step();
   endtask

   // Tick the watchdog every cycle; report the first step with a reset or wake pulse.
   task automatic run_ticks(input int n, output int first_rst, output int first_wake);
      first_rst = -1;
      first_wake = -1;
      for (int i = 1; i <= n; i++) begin
         wd_tick = 1'b1;
         step();
         if (dev_reset && first_rst < 0) first_rst = i;
         if (wake && first_wake < 0) first_wake = i;
      end
      wd_tick = 1'b0;
   endtask

   initial begin : watchdog
      #(4 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      int fr, fw, last, gap, npulse, seed;
      bit gap_ok;
      seed = $urandom(32'h5EED_0042);
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset outputs", int'({dev_reset, wake, to_n, tmr_tick}), 4'b0010);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: base overflow is the time-out
      en = 1'b1; asg = 1'b0; sleep = 1'b0;
      do_clear();
      run_ticks(300, fr, fw);
      check("R2 timeout distance", fr, 256);
      check("R7 no wake while awake", fw, -1);
      check("R9 status low after timeout", int'(to_n), 0);
      do_clear();
      check("R9 status restored by clear", int'(to_n), 1);

      // R3: postscaler periods
      asg = 1'b1; rate = 3'd0;
      do_clear();
      run_ticks(600, fr, fw);
      check("R3 div2 period", fr, 512);
      rate = 3'd1;
      do_clear();
      run_ticks(1100, fr, fw);
      check("R3/R6 div4 period after clear", fr, 1024);

      // R8: wake instead of reset while asleep
      asg = 1'b0; sleep = 1'b1;
      slp_enter = 1'b1;
      step();
      check("R6 sleep entry restores status", int'(to_n), 1);
      run_ticks(300, fr, fw);
      check("R8 wake distance", fw, 256);
      check("R8 no reset while asleep", fr, -1);
      sleep = 1'b0;

      // R4 and R6: prescaler spacing, phase kept across a clear
      asg = 1'b0; rate = 3'd2;
      last = -1; gap_ok = 1'b1; npulse = 0;
      for (int i = 0; i < 64; i++) begin
         src_tick = 1'b1;
         if (i == 29) clr_wd = 1'b1;
         step();
         if (tmr_tick) begin
            npulse++;
            if (last >= 0) begin
               gap = i - last;
               if (gap != 8) gap_ok = 1'b0;
            end
            last = i;
         end
      end
      src_tick = 1'b0;
      check("R4 pulse count div8", npulse, 8);
      check("R6 prescaler phase kept over clear", int'(gap_ok), 1);

      // R5: passthrough when the watchdog owns the scaler
      asg = 1'b1;
      for (int i = 0; i < 16; i++) begin
         src_tick = i[0] ^ i[2];
         step();
         check("R5 passthrough", int'(tmr_tick), int'(src_tick));
      end
      src_tick = 1'b0;

      // R10: disabled watchdog is silent
      asg = 1'b0;
      do_clear();
      en = 1'b0;
      run_ticks(600, fr, fw);
      check("R10 no reset when disabled", fr, -1);
      check("R10 no wake when disabled", fw, -1);
      en = 1'b1;
      run_ticks(300, fr, fw);
      check("R10 count frozen while disabled", fr, 256);

      // R11: clear on the overflowing tick
      do_clear();
      run_ticks(255, fr, fw);
      clr_wd = 1'b1; wd_tick = 1'b1;
      step();
      wd_tick = 1'b0;
      step();
      check("R11 clear suppresses timeout", int'(dev_reset), 0);
      run_ticks(300, fr, fw);
      check("R11 full period after coincident clear", fr, 256);

      // Random phase compared against the model
      for (int i = 0; i < 20000; i++) begin
         if ($urandom_range(0, 399) == 0) asg = ~asg;
         if ($urandom_range(0, 199) == 0) rate = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 499) == 0) sleep = ~sleep;
         if ($urandom_range(0, 999) == 0) en = ~en;
         wd_tick   = ($urandom_range(0, 3) != 0);
         src_tick  = $urandom_range(0, 1) == 1;
         clr_wd    = ($urandom_range(0, 2999) == 0);
         slp_enter = ($urandom_range(0, 4999) == 0);
         step();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule